// File: doc/BRIEF.md
# Two-Channel I2C Bus Selector Target

This block is an I2C target that decides which of two downstream bus segments are joined to the upstream bus. A host addresses it, then writes a control byte whose two low bits say which segments to connect: none, either one, or both. When several data bytes follow one address, only the final byte is kept. The new selection is held back and drives the channel-enable outputs only once the host places a STOP on the bus. Connecting a segment at that moment means every line is idle and high, so no false bus condition appears on the segment being joined.

A read returns one status byte. Its two low bits show the stored selection. Two further bits show the live state of two active-low interrupt inputs. All other bits read as zero. The target address is fixed in its five upper bits. Its two lowest bits come from two strap inputs, so four of these selectors can share one bus. SCL and SDA are oversampled on a fast system clock, and SDA is driven through an open-drain enable.

Top module: `i2csw_channel_switch`

## Requirements
- R1: While reset is asserted, and after reset is released, `chan_en` is 00, the stored selection reads back as 00 and `sda_oe` is low.
- R2: The target responds to the 7-bit address `11110`, `addr_sel[1]`, `addr_sel[0]` followed by the R/W bit. The write address bytes are F0h, F2h, F4h and F6h, and the read bytes are one higher. On a match, the target pulls SDA low during the ninth clock of the address byte. On any other address it does not.
- R3: After a matching write address, every data byte is acknowledged by pulling SDA low during its ninth clock.
- R4: When a write carries several data bytes, the selection stored is taken from the last byte received.
- R5: `chan_en` does not change during a transaction. It takes the stored selection when a STOP condition (SDA rising while SCL is high) is detected.
- R6: Control byte bit 0 enables `chan_en[0]` and bit 1 enables `chan_en[1]`. All four combinations are valid.
- R7: In the status byte, bits 1:0 hold the stored selection and bits 3:2 and 7:6 read 0, whatever was written to them.
- R8: Status bit 4 reads 1 while `int_n[0]` is low, and bit 5 reads 1 while `int_n[1]` is low. Values written to bits 5:4 have no effect on what is read.
- R9: A repeated START (SDA falling while SCL is high) in the middle of a write does not apply the pending selection. The next STOP applies it.
- R10: A transaction with a non-matching address is ignored. No byte is acknowledged, no data is driven, and the stored selection is unchanged.
- R11: Read data leaves the target MSB first. If the host acknowledges a byte, another status byte follows. If it does not, the target releases SDA until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| scl_i | input | 1 | Level of the bus SCL line |
| sda_i | input | 1 | Level of the bus SDA line |
| sda_oe | output | 1 | When high, pulls SDA low (open-drain) |
| addr_sel | input | 2 | Address straps, the two lowest address bits |
| int_n | input | 2 | Active-low interrupt inputs of the two channels |
| chan_en | output | 2 | Enables of downstream channel 1 and channel 0 |

## Verification
The bench sweeps every strap setting against every possible address. A wrong decoder would acknowledge a neighbour's address, or would store data that was meant for a neighbour. It watches `chan_en` between the data acknowledge and the STOP, which catches a design that applies the selection as soon as the byte arrives. It also checks that a repeated START leaves `chan_en` untouched until the following STOP. Status reads cover all combinations of channel bits and interrupt levels with every upper bit written as one. A design that echoed written bits or inverted interrupt polarity would return a byte the bench does not expect. Multi-byte writes and acknowledged multi-byte reads catch a design that kept the first byte, or that stopped driving after one byte.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CH_W    = 2;
  localparam int unsigned INT_W   = 2;
  localparam int unsigned INT_LSB = 4;
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/i2csw_rst_sync.sv
module i2csw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2csw_bus_cond.sv
module i2csw_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2csw_target_fsm.sv
module i2csw_target_fsm
  import i2csw_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [CH_W-1:0]   wr_chan
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] shf_q, shf_d;
  logic              oe_q, oe_d;
  logic              rnw_q, rnw_d;
  logic              more_q, more_d;
  logic              addr_hit;

  assign addr_hit = (shf_q[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel});

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    shf_d   = shf_q;
    oe_d    = oe_q;
    rnw_d   = rnw_q;
    more_d  = more_q;
    wr_stb  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      bcnt_d  = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      oe_d    = 1'b0;
      bcnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise && bcnt_q != FULL) begin
            shf_d  = {shf_q[BYTE_W-2:0], sda_s};
            bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall && bcnt_q == FULL) begin
            bcnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_d = ST_ADDR_ACK;
                oe_d    = 1'b1;
                rnw_d   = shf_q[0];
              end else begin
                state_d = ST_SKIP;
              end
            end else begin
              wr_stb  = 1'b1;
              state_d = ST_WR_ACK;
              oe_d    = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rnw_q) begin
              state_d = ST_RD;
              shf_d   = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
            end else begin
              state_d = ST_WR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_d = ST_WR;
            oe_d    = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bcnt_q == FULL) begin
              state_d = ST_RD_ACK;
              oe_d    = 1'b0;
              bcnt_d  = '0;
            end else begin
              shf_d = {shf_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~shf_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            more_d = ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              state_d = ST_RD;
              shf_d   = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      shf_q   <= '0;
      oe_q    <= 1'b0;
      rnw_q   <= 1'b0;
      more_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      shf_q   <= shf_d;
      oe_q    <= oe_d;
      rnw_q   <= rnw_d;
      more_q  <= more_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_chan = shf_q[CH_W-1:0];

  // Our own SDA edges are placed only while SCL is low (R3, R11)
  assert_oe_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);
  // A stored data byte is acknowledged in the following cycle
  assert_ack_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> oe_q);
  // An ignored transaction never drives the bus
  assert_skip_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !oe_q);
endmodule

// File: rtl/i2csw_ctrl_reg.sv
module i2csw_ctrl_reg
  import i2csw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic              stop_det,
  input  logic [INT_W-1:0]  int_s_n,
  output logic [CH_W-1:0]   chan_en,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [CH_W-1:0] sel_q, sel_d;
  logic [CH_W-1:0] en_q, en_d;

  always_comb begin
    sel_d = wr_stb   ? wr_chan : sel_q;
    en_d  = stop_det ? sel_q   : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    rd_byte                    = '0;
    rd_byte[CH_W-1:0]          = sel_q;
    rd_byte[INT_LSB +: INT_W]  = ~int_s_n;
  end

  assign chan_en = en_q;

  // Enables move only at a STOP (R5, R9)
  assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_det |=> $stable(en_q));
  // At a STOP the enables take the stored selection
  assert_en_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (en_q == $past(sel_q)));
  // A data byte never lands in the same cycle as a STOP
  assert_wr_not_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !stop_det);
endmodule

// File: rtl/i2csw_channel_switch.sv
module i2csw_channel_switch
  import i2csw_pkg::*;
#(
  parameter logic [4:0]  ADDR_PREFIX = 5'b11110,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_sel,
  input  logic [1:0] int_n,
  output logic [1:0] chan_en
);
  logic              rst_n_s;
  logic [1:0]        bus_s;
  logic [INT_W-1:0]  int_s_n;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_stb;
  logic [CH_W-1:0]   wr_chan;
  logic [BYTE_W-1:0] rd_byte;

  i2csw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  i2csw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  i2csw_sync #(.W(INT_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_int_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(int_n), .q_o(int_s_n)
  );

  i2csw_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n_s), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2csw_target_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_chan(wr_chan)
  );

  i2csw_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n_s), .wr_stb(wr_stb), .wr_chan(wr_chan),
    .stop_det(stop_det), .int_s_n(int_s_n),
    .chan_en(chan_en), .rd_byte(rd_byte)
  );
endmodule

// File: tb/i2csw_channel_switch_test.sv
`timescale 1ns/1ps
module i2csw_channel_switch_test;
  localparam int CLK_NS = 4;
  localparam int Q_NS   = 20 * CLK_NS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl;
  logic       sda_drv;
  logic       sda_oe;
  logic       sda_bus;
  logic [1:0] addr_sel;
  logic [1:0] int_n;
  logic [1:0] chan_en;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  i2csw_channel_switch uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .int_n(int_n), .chan_en(chan_en)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sda_drv = b; #Q_NS; scl = 1'b1; #Q_NS; scl = 1'b0; #Q_NS;
  endtask

  task automatic bit_in(output logic b);
    sda_drv = 1'b1; #Q_NS; scl = 1'b1; #Q_NS; b = sda_bus; scl = 1'b0; #Q_NS;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; #Q_NS; scl = 1'b1; #Q_NS; sda_drv = 1'b0; #Q_NS; scl = 1'b0; #Q_NS;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; #Q_NS; scl = 1'b1; #Q_NS; sda_drv = 1'b1; #Q_NS;
    #(10*CLK_NS);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~give_ack);
  endtask

  function automatic logic [7:0] status(input logic [1:0] sel, input logic [1:0] irq_n);
    return {2'b00, ~irq_n[1], ~irq_n[0], 2'b00, sel};
  endfunction

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    logic [1:0] prev_en;
    scl = 1'b1; sda_drv = 1'b1; addr_sel = 2'b00; int_n = 2'b11; rst_n = 1'b0;
    #(10*CLK_NS + 1);
    check("R1 reset chan_en", {6'd0, chan_en}, 8'h00);
    check("R1 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    #(10*CLK_NS);
    prev_en = 2'b00;

    // R2/R3/R5/R6/R10: every strap against every address
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      for (int p = 0; p < 4; p++) begin
        logic [1:0] val = 2'((s + p + 1) % 4);
        bus_start();
        wr_byte({5'b11110, 2'(p), 1'b0}, ack);
        check($sformatf("R2 addr ack s=%0d p=%0d", s, p), {7'd0, ack}, {7'd0, p == s});
        wr_byte({6'b101011, val}, ack);
        check("R3/R10 data ack", {7'd0, ack}, {7'd0, p == s});
        check("R5 no change before stop", {6'd0, chan_en}, {6'd0, prev_en});
        bus_stop();
        if (p == s) prev_en = val;
        check("R6/R10 chan_en after stop", {6'd0, chan_en}, {6'd0, prev_en});
      end
    end

    // R10: read with a foreign address returns released bus
    addr_sel = 2'b01;
    bus_start();
    wr_byte(8'hF5, ack);
    check("R10 foreign read nack", {7'd0, ack}, 8'h00);
    rd_byte(rb, 1'b0);
    check("R10 foreign read idle", rb, 8'hFF);
    bus_stop();

    // R7/R8: status over all selections and interrupt levels
    addr_sel = 2'b10;
    for (int c = 0; c < 4; c++) begin
      bus_start();
      wr_byte(8'hF4, ack);
      wr_byte({6'b111111, 2'(c)}, ack);
      bus_stop();
      check("R6 all-ones write", {6'd0, chan_en}, {6'd0, 2'(c)});
      for (int k = 0; k < 4; k++) begin
        int_n = 2'(k);
        #(10*CLK_NS);
        bus_start();
        wr_byte(8'hF5, ack);
        check("R2 read addr ack", {7'd0, ack}, 8'h01);
        rd_byte(rb, 1'b0);
        check($sformatf("R7/R8 status c=%0d k=%0d", c, k), rb, status(2'(c), 2'(k)));
        check("R11 released after nack", {7'd0, sda_oe}, 8'h00);
        bus_stop();
      end
    end
    int_n = 2'b10;

    // R4: several data bytes, last one kept
    bus_start();
    wr_byte(8'hF4, ack);
    wr_byte(8'h01, ack);
    wr_byte(8'h03, ack);
    wr_byte(8'h02, ack);
    check("R3 third data ack", {7'd0, ack}, 8'h01);
    check("R5 hold during multi", {6'd0, chan_en}, 8'h03);
    bus_stop();
    check("R4 last byte kept", {6'd0, chan_en}, 8'h02);

    // R9/R11: repeated start, two-byte read
    bus_start();
    wr_byte(8'hF4, ack);
    wr_byte(8'h01, ack);
    bus_start();
    wr_byte(8'hF5, ack);
    check("R9 rep-start read ack", {7'd0, ack}, 8'h01);
    check("R9 not applied at rep start", {6'd0, chan_en}, 8'h02);
    rd_byte(rb, 1'b1);
    check("R11 first status byte", rb, status(2'b01, 2'b10));
    rd_byte(rb, 1'b0);
    check("R11 second status byte", rb, status(2'b01, 2'b10));
    check("R9 still held", {6'd0, chan_en}, 8'h02);
    bus_stop();
    check("R9 applied at stop", {6'd0, chan_en}, 8'h01);

    // R1: reset in operation
    rst_n = 1'b0;
    #(4*CLK_NS);
    check("R1 reset clears chan_en", {6'd0, chan_en}, 8'h00);
    rst_n = 1'b1;
    #(10*CLK_NS);
    bus_start();
    wr_byte(8'hF5, ack);
    rd_byte(rb, 1'b0);
    bus_stop();
    check("R1 register cleared", rb, status(2'b00, 2'b10));

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule